// File: doc/BRIEF.md
# Interrupt Distributor Write Decoder

This block sits behind the register port of an interrupt distributor and turns byte and halfword writes into updates of the per-interrupt configuration. It holds the global distributor enable and, for every implemented interrupt ID, an enable bit, a pending bit, a priority byte, a CPU target byte, a model flag and an edge/level trigger flag. Offsets are relative to the distributor base. Each write is classified by region. Set and clear bitmaps, per-ID byte arrays and packed two-bit configuration fields all go through the same byte-lane decoder. A halfword write is handled as two lanes in the same cycle.

Every write gets exactly one response in the following cycle. A response state machine has three states. RS_IDLE means no write was seen. RS_UPDATE means a legal write was applied, and it drives `update_strobe` so that a downstream arbiter re-evaluates. RS_FAULT means an illegal access was rejected, and it drives `bad_access`. From any state, the next state is RS_UPDATE after a legal write, RS_FAULT after an illegal write, and RS_IDLE when there is no write. Sampled level inputs let the block apply one rule: enabling a raised level-sensitive line also makes it pending.

Top module: `dist_wr_decoder`

## Requirements
- R1: After reset, the distributor enable and all per-ID state read as zero, and both `update_strobe` and `bad_access` are low.
- R2: A byte write to offset 0x000 loads bit 0 into `dist_enable`. Byte writes to 0x001..0x003 are legal and change nothing. Any other offset below 0x100 is illegal.
- R3: At 0x100..0x17F, data bit b of the byte at offset X sets the enable of ID (X-0x100)*8+b. At 0x180..0x1FF, a set bit clears that enable in the same way. Zero bits have no effect.
- R4: At 0x200..0x27F, a set bit makes ID (X-0x200)*8+b pending. At 0x280..0x2FF, a set bit clears the pending bit of ID (X-0x280)*8+b.
- R5: Setting the enable of an ID whose `irq_level` bit is high and whose trigger flag is 0 (level-sensitive) also sets its pending bit. An ID with trigger 1 (edge) gets no pending bit from being enabled.
- R6: A byte written at 0x400+ID becomes the priority of that ID. A byte written at 0x800+ID becomes its target mask.
- R7: At 0xC00..0xEFF, the byte at offset X covers IDs 4*(X-0xC00)+i for i=0..3. Bit 2i is written to the model flag and bit 2i+1 to the trigger flag (1 = edge). Both flags are overwritten, so 0 clears them.
- R8: A write is illegal if it is a byte write to 0x300..0x3FF, a byte write at or above 0xF00, or a write whose first computed ID is at or beyond NUM_IRQ. An illegal write raises `bad_access` for one cycle, does not raise `update_strobe`, and changes no state.
- R9: A halfword write to exactly 0xF00 makes ID `wr_data[9:0]` pending and ignores `wr_data[15:10]`. It is illegal when that ID is at or beyond NUM_IRQ.
- R10: Any other halfword write acts as two byte writes: `wr_data[7:0]` at the offset and `wr_data[15:8]` at the offset plus one. If either byte is illegal, the whole halfword is rejected and changes nothing.
- R11: Each write is answered in the next cycle by exactly one of `update_strobe` or `bad_access`, which appears together with the updated state. A cycle without a write is answered by neither. Writes may arrive on back-to-back cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_valid | input | 1 | Write request this cycle |
| wr_half | input | 1 | 1 = halfword write, 0 = byte write |
| wr_offset | input | 12 | Byte offset from the distributor base |
| wr_data | input | 16 | Write data; a byte write uses [7:0] |
| irq_level | input | NUM_IRQ | Current input level of each interrupt line |
| dist_enable | output | 1 | Global distributor enable |
| irq_enable | output | NUM_IRQ | Per-ID enable bits |
| irq_pending | output | NUM_IRQ | Per-ID pending bits |
| irq_prio | output | NUM_IRQ*8 | Priority bytes, ID i at [8i+7:8i] |
| irq_target | output | NUM_IRQ*8 | Target masks, ID i at [8i+7:8i] |
| irq_model | output | NUM_IRQ | Per-ID model flags |
| irq_edge | output | NUM_IRQ | Per-ID trigger flags, 1 = edge |
| update_strobe | output | 1 | One-cycle pulse after a legal write |
| bad_access | output | 1 | One-cycle pulse after an illegal write |

## Verification
The hardest case to reach from the ports is a halfword whose low byte is legal and whose high byte is not, as when the high byte lands on the first ID past the implemented count. The stimulus aims a halfword at the last priority byte so that the high lane overflows, then confirms that the low byte's priority stayed unchanged. Checking the enable-implies-pending rule also needs a set-up sequence. The level inputs are held, one ID's trigger is flipped to edge through a configuration write, and the enables of both a level ID and an edge ID are then set, so their pending bits must differ.

// File: rtl/dist_pkg.sv
package dist_pkg;

    localparam int IDX_W = 12;

    typedef enum logic [3:0] {
        RG_CTRL,
        RG_RSVD,
        RG_EN_SET,
        RG_EN_CLR,
        RG_PD_SET,
        RG_PD_CLR,
        RG_PRIO,
        RG_TGT,
        RG_CFG,
        RG_BAD
    } region_e;

    typedef struct packed {
        region_e            region;
        logic [IDX_W-1:0]   base;
        logic [7:0]         data;
        logic               ok;
    } lane_t;

    typedef enum logic [1:0] {
        RS_IDLE,
        RS_UPDATE,
        RS_FAULT
    } resp_e;

endpackage

// File: rtl/dist_lane_decode.sv
module dist_lane_decode
    import dist_pkg::*;
#(
    parameter int NUM_IRQ = 64
) (
    input  logic [12:0] off,
    input  logic [7:0]  data,
    output lane_t       lane
);

    localparam logic [IDX_W-1:0] NIRQ = IDX_W'(NUM_IRQ);

    always_comb begin
        lane.region = RG_BAD;
        lane.base   = '0;
        lane.data   = data;
        if (off == 13'h000) begin
            lane.region = RG_CTRL;
        end else if (off < 13'h004) begin
            lane.region = RG_RSVD;
        end else if (off < 13'h100) begin
            lane.region = RG_BAD;
        end else if (off < 13'h180) begin
            lane.region = RG_EN_SET;
            lane.base   = IDX_W'((off - 13'h100) << 3);
        end else if (off < 13'h200) begin
            lane.region = RG_EN_CLR;
            lane.base   = IDX_W'((off - 13'h180) << 3);
        end else if (off < 13'h280) begin
            lane.region = RG_PD_SET;
            lane.base   = IDX_W'((off - 13'h200) << 3);
        end else if (off < 13'h300) begin
            lane.region = RG_PD_CLR;
            lane.base   = IDX_W'((off - 13'h280) << 3);
        end else if (off < 13'h400) begin
            lane.region = RG_BAD;
        end else if (off < 13'h800) begin
            lane.region = RG_PRIO;
            lane.base   = IDX_W'(off - 13'h400);
        end else if (off < 13'hC00) begin
            lane.region = RG_TGT;
            lane.base   = IDX_W'(off - 13'h800);
        end else if (off < 13'hF00) begin
            lane.region = RG_CFG;
            lane.base   = IDX_W'((off - 13'hC00) << 2);
        end
        lane.ok = (lane.region != RG_BAD) && (lane.base < NIRQ);
    end

endmodule

// File: rtl/dist_irq_slice.sv
module dist_irq_slice
    import dist_pkg::*;
#(
    parameter int ID = 0
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        commit,
    input  lane_t       lane_a,
    input  lane_t       lane_b,
    input  logic        soft_hit,
    input  logic        level,
    output logic        en,
    output logic        pend,
    output logic [7:0]  prio,
    output logic [7:0]  tgt,
    output logic        model,
    output logic        edge_trig
);

    localparam logic [IDX_W-1:0] IDV = IDX_W'(ID);

    lane_t      lanes [2];
    logic       en_set, en_clr, pd_set, pd_clr;
    logic       prio_we, tgt_we, cfg_we;
    logic [7:0] prio_d, tgt_d;
    logic [1:0] cfg_d;

    assign lanes[0] = lane_a;
    assign lanes[1] = lane_b;

    always_comb begin
        en_set  = 1'b0;
        en_clr  = 1'b0;
        pd_set  = soft_hit;
        pd_clr  = 1'b0;
        prio_we = 1'b0;
        tgt_we  = 1'b0;
        cfg_we  = 1'b0;
        prio_d  = prio;
        tgt_d   = tgt;
        cfg_d   = {edge_trig, model};
        for (int k = 0; k < 2; k++) begin
            logic [IDX_W-1:0] rel;
            logic             in8;
            rel = IDV - lanes[k].base;
            in8 = (rel < IDX_W'(8)) && lanes[k].data[rel[2:0]];
            case (lanes[k].region)
                RG_EN_SET: if (in8) en_set = 1'b1;
                RG_EN_CLR: if (in8) en_clr = 1'b1;
                RG_PD_SET: if (in8) pd_set = 1'b1;
                RG_PD_CLR: if (in8) pd_clr = 1'b1;
                RG_PRIO: if (rel == '0) begin
                    prio_we = 1'b1;
                    prio_d  = lanes[k].data;
                end
                RG_TGT: if (rel == '0) begin
                    tgt_we = 1'b1;
                    tgt_d  = lanes[k].data;
                end
                RG_CFG: if (rel < IDX_W'(4)) begin
                    cfg_we = 1'b1;
                    cfg_d  = lanes[k].data[{rel[1:0], 1'b0} +: 2];
                end
                default: ;
            endcase
        end
        // raised level-sensitive line becomes pending when enabled
        if (en_set && level && !edge_trig) pd_set = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en        <= 1'b0;
            pend      <= 1'b0;
            prio      <= '0;
            tgt       <= '0;
            model     <= 1'b0;
            edge_trig <= 1'b0;
        end else if (commit) begin
            en   <= (en | en_set) & ~en_clr;
            pend <= (pend | pd_set) & ~pd_clr;
            if (prio_we) prio <= prio_d;
            if (tgt_we)  tgt  <= tgt_d;
            if (cfg_we) begin
                model     <= cfg_d[0];
                edge_trig <= cfg_d[1];
            end
        end
    end

endmodule

// File: rtl/dist_resp_fsm.sv
module dist_resp_fsm
    import dist_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic wr_valid,
    input  logic legal,
    output logic update_strobe,
    output logic bad_access
);

    resp_e state, state_nx;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= RS_IDLE;
        else        state <= state_nx;
    end

    always_comb begin
        if (!wr_valid)  state_nx = RS_IDLE;
        else if (legal) state_nx = RS_UPDATE;
        else            state_nx = RS_FAULT;
    end

    always_comb begin
        update_strobe = 1'b0;
        bad_access    = 1'b0;
        unique case (state)
            RS_IDLE:   ;
            RS_UPDATE: update_strobe = 1'b1;
            RS_FAULT:  bad_access    = 1'b1;
            default:   ;
        endcase
    end

endmodule

// File: rtl/dist_wr_decoder.sv
module dist_wr_decoder
    import dist_pkg::*;
#(
    parameter int NUM_IRQ = 64
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr_valid,
    input  logic                  wr_half,
    input  logic [11:0]           wr_offset,
    input  logic [15:0]           wr_data,
    input  logic [NUM_IRQ-1:0]    irq_level,
    output logic                  dist_enable,
    output logic [NUM_IRQ-1:0]    irq_enable,
    output logic [NUM_IRQ-1:0]    irq_pending,
    output logic [NUM_IRQ*8-1:0]  irq_prio,
    output logic [NUM_IRQ*8-1:0]  irq_target,
    output logic [NUM_IRQ-1:0]    irq_model,
    output logic [NUM_IRQ-1:0]    irq_edge,
    output logic                  update_strobe,
    output logic                  bad_access
);

    localparam logic [11:0]      SOFT_OFF = 12'hF00;
    localparam logic [IDX_W-1:0] NIRQ     = IDX_W'(NUM_IRQ);

    lane_t             lane_lo, lane_hi, lane_b;
    logic              soft_wr, soft_ok, legal, commit;
    logic [IDX_W-1:0]  soft_id;

    assign soft_wr = wr_half && (wr_offset == SOFT_OFF);
    assign soft_id = {2'b00, wr_data[9:0]};
    assign soft_ok = soft_id < NIRQ;

    dist_lane_decode #(.NUM_IRQ(NUM_IRQ)) u_lane_lo (
        .off  ({1'b0, wr_offset}),
        .data (wr_data[7:0]),
        .lane (lane_lo)
    );

    dist_lane_decode #(.NUM_IRQ(NUM_IRQ)) u_lane_hi (
        .off  ({1'b0, wr_offset} + 13'd1),
        .data (wr_data[15:8]),
        .lane (lane_hi)
    );

    always_comb begin
        lane_b = lane_hi;
        if (!wr_half) begin
            lane_b.region = RG_RSVD;
            lane_b.ok     = 1'b1;
        end
    end

    always_comb begin
        if (soft_wr)      legal = soft_ok;
        else if (wr_half) legal = lane_lo.ok && lane_hi.ok;
        else              legal = lane_lo.ok;
    end

    assign commit = wr_valid && legal;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            dist_enable <= 1'b0;
        else if (commit && lane_lo.region == RG_CTRL)
            dist_enable <= lane_lo.data[0];
    end

    for (genvar i = 0; i < NUM_IRQ; i++) begin : g_slice
        logic hit;
        assign hit = soft_wr && (soft_id == IDX_W'(i));
        dist_irq_slice #(.ID(i)) u_slice (
            .clk       (clk),
            .rst_n     (rst_n),
            .commit    (commit),
            .lane_a    (lane_lo),
            .lane_b    (lane_b),
            .soft_hit  (hit),
            .level     (irq_level[i]),
            .en        (irq_enable[i]),
            .pend      (irq_pending[i]),
            .prio      (irq_prio[i*8 +: 8]),
            .tgt       (irq_target[i*8 +: 8]),
            .model     (irq_model[i]),
            .edge_trig (irq_edge[i])
        );
    end

    dist_resp_fsm u_resp (
        .clk           (clk),
        .rst_n         (rst_n),
        .wr_valid      (wr_valid),
        .legal         (legal),
        .update_strobe (update_strobe),
        .bad_access    (bad_access)
    );

endmodule

// File: rtl/dist_wr_decoder_chk.sv
module dist_wr_decoder_chk #(
    parameter int NUM_IRQ = 64
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  wr_valid,
    input logic                  wr_half,
    input logic [11:0]           wr_offset,
    input logic                  dist_enable,
    input logic [NUM_IRQ-1:0]    irq_enable,
    input logic [NUM_IRQ-1:0]    irq_pending,
    input logic [NUM_IRQ*8-1:0]  irq_prio,
    input logic                  update_strobe,
    input logic                  bad_access
);

    AST_WRITE_ANSWERED: assert property (@(posedge clk) disable iff (!rst_n)
        wr_valid |=> (update_strobe != bad_access)); // R11

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_valid |=> (!update_strobe && !bad_access)); // R11

    AST_FAULT_FREEZES: assert property (@(posedge clk) disable iff (!rst_n)
        bad_access |-> ($stable(irq_pending) && $stable(irq_enable)
                        && $stable(irq_prio) && $stable(dist_enable))); // R8

    AST_NO_STROBE_NO_CHANGE: assert property (@(posedge clk) disable iff (!rst_n)
        !update_strobe |-> ($stable(irq_pending) && $stable(irq_enable))); // R11

    AST_ACTIVE_RANGE_BAD: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid && !wr_half && wr_offset[11:8] == 4'h3) |=> bad_access); // R8

    AST_BYTE_TOP_BAD: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid && !wr_half && wr_offset >= 12'hF00) |=> bad_access); // R8

    AST_CTRL_PAD_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid && !wr_half && wr_offset >= 12'h001 && wr_offset <= 12'h003)
        |=> (update_strobe && $stable(dist_enable))); // R2

endmodule

bind dist_wr_decoder dist_wr_decoder_chk #(.NUM_IRQ(NUM_IRQ)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .wr_valid      (wr_valid),
    .wr_half       (wr_half),
    .wr_offset     (wr_offset),
    .dist_enable   (dist_enable),
    .irq_enable    (irq_enable),
    .irq_pending   (irq_pending),
    .irq_prio      (irq_prio),
    .update_strobe (update_strobe),
    .bad_access    (bad_access)
);

// File: tb/dist_wr_decoder_tb.sv
module dist_wr_decoder_tb;

    localparam int N = 64;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           wr_valid = 1'b0;
    logic           wr_half = 1'b0;
    logic [11:0]    wr_offset = '0;
    logic [15:0]    wr_data = '0;
    logic [N-1:0]   irq_level = '0;
    logic           dist_enable, update_strobe, bad_access;
    logic [N-1:0]   irq_enable, irq_pending, irq_model, irq_edge;
    logic [N*8-1:0] irq_prio, irq_target;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    dist_wr_decoder #(.NUM_IRQ(N)) u_dut (
        .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_half(wr_half),
        .wr_offset(wr_offset), .wr_data(wr_data), .irq_level(irq_level),
        .dist_enable(dist_enable), .irq_enable(irq_enable),
        .irq_pending(irq_pending), .irq_prio(irq_prio),
        .irq_target(irq_target), .irq_model(irq_model), .irq_edge(irq_edge),
        .update_strobe(update_strobe), .bad_access(bad_access)
    );

    localparam logic [3:0] K_DEN = 4'd1, K_EN = 4'd2, K_PEND = 4'd3,
                           K_PRIO = 4'd4, K_TGT = 4'd5, K_MODEL = 4'd6,
                           K_EDGE = 4'd7;

    typedef struct packed {
        logic        half;
        logic [11:0] off;
        logic [15:0] data;
        logic        bad;
        logic [3:0]  kind;
        logic [7:0]  idx;
        logic [7:0]  val;
        logic [7:0]  req;
    } vec_t;

    localparam int NV = 28;
    localparam vec_t VECS [NV] = '{
        '{1'b0, 12'h000, 16'h0001, 1'b0, K_DEN,   8'd0,  8'h01, 8'd2},  // R2 enable on
        '{1'b0, 12'h002, 16'h00FF, 1'b0, K_DEN,   8'd0,  8'h01, 8'd2},  // R2 padding ignored
        '{1'b0, 12'h004, 16'h00FF, 1'b1, K_DEN,   8'd0,  8'h01, 8'd8},  // R8 low illegal
        '{1'b0, 12'h101, 16'h0005, 1'b0, K_EN,    8'd10, 8'h01, 8'd3},  // R3 set IDs 8,10
        '{1'b0, 12'h101, 16'h0000, 1'b0, K_EN,    8'd8,  8'h01, 8'd3},  // R3 zero bits no effect
        '{1'b0, 12'h181, 16'h0001, 1'b0, K_EN,    8'd8,  8'h00, 8'd3},  // R3 clear ID 8
        '{1'b0, 12'h181, 16'h0000, 1'b0, K_EN,    8'd10, 8'h01, 8'd3},  // R3 ID 10 kept
        '{1'b0, 12'h100, 16'h0020, 1'b0, K_PEND,  8'd5,  8'h01, 8'd5},  // R5 level line
        '{1'b0, 12'hC01, 16'h0020, 1'b0, K_EDGE,  8'd6,  8'h01, 8'd7},  // R7 ID 6 edge
        '{1'b0, 12'h100, 16'h0040, 1'b0, K_PEND,  8'd6,  8'h00, 8'd5},  // R5 edge line
        '{1'b0, 12'hC00, 16'h0001, 1'b0, K_MODEL, 8'd0,  8'h01, 8'd7},  // R7 model set
        '{1'b0, 12'hC00, 16'h0002, 1'b0, K_MODEL, 8'd0,  8'h00, 8'd7},  // R7 model cleared
        '{1'b0, 12'hC00, 16'h0002, 1'b0, K_EDGE,  8'd0,  8'h01, 8'd7},  // R7 trigger set
        '{1'b0, 12'h203, 16'h0080, 1'b0, K_PEND,  8'd31, 8'h01, 8'd4},  // R4 set pending
        '{1'b0, 12'h283, 16'h0080, 1'b0, K_PEND,  8'd31, 8'h00, 8'd4},  // R4 clear pending
        '{1'b0, 12'h42A, 16'h00A5, 1'b0, K_PRIO,  8'd42, 8'hA5, 8'd6},  // R6 priority
        '{1'b0, 12'h83F, 16'h0003, 1'b0, K_TGT,   8'd63, 8'h03, 8'd6},  // R6 target
        '{1'b0, 12'h308, 16'h00FF, 1'b1, K_PRIO,  8'd42, 8'hA5, 8'd8},  // R8 active range
        '{1'b0, 12'h108, 16'h00FF, 1'b1, K_EN,    8'd0,  8'h00, 8'd8},  // R8 ID 64
        '{1'b0, 12'h440, 16'h0011, 1'b1, K_PRIO,  8'd0,  8'h00, 8'd8},  // R8 prio ID 64
        '{1'b0, 12'hF00, 16'h0007, 1'b1, K_PEND,  8'd7,  8'h00, 8'd8},  // R8 byte at top
        '{1'b1, 12'hF00, 16'h0409, 1'b0, K_PEND,  8'd9,  8'h01, 8'd9},  // R9 soft pend
        '{1'b1, 12'hF00, 16'h0040, 1'b1, K_PEND,  8'd0,  8'h00, 8'd9},  // R9 ID too big
        '{1'b1, 12'h200, 16'h0101, 1'b0, K_PEND,  8'd8,  8'h01, 8'd10}, // R10 both lanes
        '{1'b1, 12'h410, 16'h3322, 1'b0, K_PRIO,  8'd17, 8'h33, 8'd10}, // R10 high byte
        '{1'b1, 12'h410, 16'h3322, 1'b0, K_PRIO,  8'd16, 8'h22, 8'd10}, // R10 low byte
        '{1'b1, 12'h43F, 16'h5544, 1'b1, K_PRIO,  8'd63, 8'h00, 8'd10}, // R10 partial bad
        '{1'b1, 12'h000, 16'h0000, 1'b0, K_DEN,   8'd0,  8'h00, 8'd10}  // R10 + R2 off
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] observe(input logic [3:0] kind, input int idx);
        case (kind)
            K_DEN:   return {7'd0, dist_enable};
            K_EN:    return {7'd0, irq_enable[idx]};
            K_PEND:  return {7'd0, irq_pending[idx]};
            K_PRIO:  return irq_prio[idx*8 +: 8];
            K_TGT:   return irq_target[idx*8 +: 8];
            K_MODEL: return {7'd0, irq_model[idx]};
            K_EDGE:  return {7'd0, irq_edge[idx]};
            default: return 8'hXX;
        endcase
    endfunction

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    task automatic check_all_clear(input string req);
        check(req, {31'd0, dist_enable}, 0);
        check(req, {31'd0, |{irq_enable, irq_pending, irq_model, irq_edge}}, 0);
        check(req, {31'd0, |{irq_prio, irq_target}}, 0);
        check(req, {30'd0, update_strobe, bad_access}, 0);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual running expected done");
        finish_run();
    end

    initial begin
        irq_level = 64'h60;
        repeat (3) @(negedge clk);
        check_all_clear("R1");
        rst_n = 1'b1;
        @(negedge clk);
        check_all_clear("R1");

        for (int v = 0; v < NV; v++) begin
            string tag;
            tag = $sformatf("R%0d vec%0d", VECS[v].req, v);
            @(negedge clk);
            wr_valid  = 1'b1;
            wr_half   = VECS[v].half;
            wr_offset = VECS[v].off;
            wr_data   = VECS[v].data;
            @(negedge clk);
            wr_valid = 1'b0;
            check({tag, " R11 strobe"}, {31'd0, update_strobe}, {31'd0, !VECS[v].bad});
            check({tag, " R11 fault"},  {31'd0, bad_access},    {31'd0, VECS[v].bad});
            check(tag, {24'd0, observe(VECS[v].kind, int'(VECS[v].idx))}, {24'd0, VECS[v].val});
        end

        // R11: back-to-back writes to pending bytes, then an idle cycle
        @(negedge clk);
        wr_valid = 1'b1; wr_half = 1'b0; wr_offset = 12'h204; wr_data = 16'h0001;
        @(negedge clk);
        check("R11 b2b first", {31'd0, update_strobe}, 1);
        wr_offset = 12'h205; wr_data = 16'h0001;
        @(negedge clk);
        wr_valid = 1'b0;
        check("R11 b2b second", {31'd0, update_strobe}, 1);
        check("R4 b2b ID32", {31'd0, irq_pending[32]}, 1);
        check("R4 b2b ID40", {31'd0, irq_pending[40]}, 1);
        @(negedge clk);
        check("R11 idle", {30'd0, update_strobe, bad_access}, 0);

        // R5: enable again with the line now low gives no pending
        irq_level = '0;
        @(negedge clk);
        wr_valid = 1'b1; wr_offset = 12'h100; wr_data = 16'h0008;
        @(negedge clk);
        wr_valid = 1'b0;
        check("R5 low line", {31'd0, irq_pending[3]}, 0);
        check("R5 enabled", {31'd0, irq_enable[3]}, 1);

        // R1: reset in mid-run clears everything
        rst_n = 1'b0;
        @(negedge clk);
        check_all_clear("R1 mid-run");
        rst_n = 1'b1;
        @(negedge clk);
        finish_run();
    end

endmodule